// File: doc/BRIEF.md
# Row Multiplexing Address Sequencer

This block paces the row multiplexing of a detector readout array. A cycle counter divides time into rows of a programmable length. A row counter steps through a programmable number of rows and wraps back to row 0 at the end of every frame. For the current row the block drives one bit of a one-hot select vector. Every select is released at the start of a row, and the new row's select comes on only after two idle cycles, so two rows are never selected together.

Two strobes mark the timing: one on the first cycle of each row, and one on the first cycle of row 0, which is the return of the row address to zero. The select vector is retimed onto the falling clock edge, so it changes half a cycle after the counters. The row length and row count are taken only when a frame begins, so a change made during a frame takes effect at the next frame.

Top module: `row_mux_sequencer`

## Requirements
- R1: Each row lasts exactly the effective row length in clock cycles. The first cycle of a row is cycle 0.
- R2: While running, `rowIdx` counts 0, 1, … up to the effective row count minus 1, then returns to 0. It is 0 while idle.
- R3: `rowSel` has at most one bit set. Bit k is set only for row k, from cycle 2 to the last cycle of the row. On cycles 0 and 1 of every row all bits are 0, which gives a two-cycle gap before any new row is selected.
- R4: `rowStart` is high for exactly one cycle, on cycle 0 of every row, and is low while idle.
- R5: `arzPulse` is high only on cycle 0 of row 0. While the settings stay constant it therefore repeats every row length × row count cycles.
- R6: `rowLen` and `numRows` are sampled only when a frame starts, either on leaving idle or on a wrap. A change during a frame does not alter that frame.
- R7: The effective row length is `rowLen`, raised to 3 when it is below 3. The effective row count is `numRows`, raised to 1 when it is 0 and lowered to MAX_ROWS when it is above MAX_ROWS.
- R8: When `enable` is low at a rising edge, the block goes idle after that edge: index 0, no strobes, all selects off by the next falling edge. When `enable` is high at an edge while idle, the next cycle is cycle 0 of row 0.
- R9: An active-low `rst_n` clears the selects, the index and the strobes at once, without waiting for a clock edge.
- R10: `rowSel` updates on the falling edge of `clk`. Just after a rising edge it still holds the value of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the sequence while high |
| rowLen | input | LEN_W | Requested cycles per row |
| numRows | input | $clog2(MAX_ROWS+1) | Requested rows per frame |
| rowIdx | output | $clog2(MAX_ROWS) | Current row index |
| rowSel | output | MAX_ROWS | One-hot row-select enables, updated on the falling edge |
| rowStart | output | 1 | Pulse on cycle 0 of every row |
| arzPulse | output | 1 | Pulse when the row address returns to zero |

## Verification
The bench builds the block with MAX_ROWS = 8 and LEN_W = 5. This keeps every frame short, so a sweep can cover many combinations of row length and row count over two full frames each, and every select bit gets driven. A 4-bit row-count input can also request 9 to 15 rows, which exercises the upper clamp. Row lengths 0 to 2 exercise the lower clamp. The bench also covers settings changed mid-frame, enable dropped in the middle of a row, and a reset asserted asynchronously while running.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;
  // Strobes from the control to the row datapath
  typedef struct packed {
    logic clear;   // force row index to 0 (idle or start)
    logic step;    // advance to next row
    logic wrap;    // frame end: return to row 0
    logic gateOn;  // selects may be driven this cycle
  } seq_strobe_t;

  localparam int unsigned GAP_CYCLES = 2;
  localparam int unsigned MIN_ROW_LEN = GAP_CYCLES + 1;
endpackage

// File: rtl/rowseq_ctrl.sv
module rowseq_ctrl
  import rowseq_pkg::*;
#(
  parameter int unsigned MAX_ROWS = 64,
  parameter int unsigned LEN_W    = 12,
  localparam int unsigned ROW_W   = $clog2(MAX_ROWS),
  localparam int unsigned CNT_W   = $clog2(MAX_ROWS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [LEN_W-1:0]  rowLen,
  input  logic [CNT_W-1:0]  numRows,
  input  logic [ROW_W-1:0]  rowIdx,
  output seq_strobe_t       strb,
  output logic              rowStart,
  output logic              arzPulse
);
  logic              running;
  logic [LEN_W-1:0]  cyc;
  logic [LEN_W-1:0]  actLen;
  logic [CNT_W-1:0]  actRows;
  logic [LEN_W-1:0]  effLen;
  logic [CNT_W-1:0]  effRows;
  logic              cycLast;
  logic              rowLast;
  logic              frameEnd;
  logic              loadCfg;

  always_comb begin
    effLen = (rowLen < LEN_W'(MIN_ROW_LEN)) ? LEN_W'(MIN_ROW_LEN) : rowLen;
    if (numRows == '0)
      effRows = CNT_W'(1);
    else if (numRows > CNT_W'(MAX_ROWS))
      effRows = CNT_W'(MAX_ROWS);
    else
      effRows = numRows;
  end

  assign cycLast  = (cyc == actLen - LEN_W'(1));
  assign rowLast  = (CNT_W'(rowIdx) == actRows - CNT_W'(1));
  assign frameEnd = running && cycLast && rowLast;
  assign loadCfg  = enable && (!running || frameEnd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cyc     <= '0;
      actLen  <= LEN_W'(MIN_ROW_LEN);
      actRows <= CNT_W'(1);
    end else begin
      if (!enable) begin
        running <= 1'b0;
        cyc     <= '0;
      end else if (!running) begin
        running <= 1'b1;
        cyc     <= '0;
      end else begin
        cyc <= cycLast ? '0 : cyc + LEN_W'(1);
      end
      if (loadCfg) begin
        actLen  <= effLen;
        actRows <= effRows;
      end
    end
  end

  always_comb begin
    strb.clear  = !enable || !running;
    strb.step   = enable && running && cycLast && !rowLast;
    strb.wrap   = enable && frameEnd;
    strb.gateOn = running && (cyc >= LEN_W'(GAP_CYCLES));
  end

  assign rowStart = running && (cyc == '0);
  assign arzPulse = rowStart && (rowIdx == '0);

  // R1: cycle counter stays inside the active row length
  p_cyc_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cyc < actLen));

  // R2: row index from the datapath stays below the active row count
  p_row_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (CNT_W'(rowIdx) < actRows));

  // R6: active settings hold for the whole frame
  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && enable && !frameEnd) |=> ($stable(actLen) && $stable(actRows)));

  // R7: active row length never below the minimum
  p_min_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (actLen >= LEN_W'(MIN_ROW_LEN)));
endmodule

// File: rtl/rowseq_datapath.sv
module rowseq_datapath
  import rowseq_pkg::*;
#(
  parameter int unsigned MAX_ROWS = 64,
  localparam int unsigned ROW_W   = $clog2(MAX_ROWS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  seq_strobe_t         strb,
  output logic [ROW_W-1:0]    rowIdx,
  output logic [MAX_ROWS-1:0] rowSel
);
  logic [MAX_ROWS-1:0] decoded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rowIdx <= '0;
    else if (strb.clear || strb.wrap)
      rowIdx <= '0;
    else if (strb.step)
      rowIdx <= rowIdx + ROW_W'(1);
  end

  for (genvar g = 0; g < MAX_ROWS; g++) begin : g_dec
    assign decoded[g] = strb.gateOn && (rowIdx == ROW_W'(g));
  end

  // Selects are retimed onto the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)
      rowSel <= '0;
    else
      rowSel <= decoded;
  end

  // R3: never more than one row selected
  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rowSel));

  // R3: break before make, no direct switch from one select to another
  p_bbm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((rowSel != '0) && ($past(rowSel) != '0)) |-> (rowSel == $past(rowSel)));

  // R2: a step advances the index by one
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.step && !strb.clear) |=> (rowIdx == ROW_W'($past(rowIdx) + ROW_W'(1))));
endmodule

// File: rtl/row_mux_sequencer.sv
module row_mux_sequencer
  import rowseq_pkg::*;
#(
  parameter int unsigned MAX_ROWS = 64,
  parameter int unsigned LEN_W    = 12,
  localparam int unsigned ROW_W   = $clog2(MAX_ROWS),
  localparam int unsigned CNT_W   = $clog2(MAX_ROWS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [LEN_W-1:0]    rowLen,
  input  logic [CNT_W-1:0]    numRows,
  output logic [ROW_W-1:0]    rowIdx,
  output logic [MAX_ROWS-1:0] rowSel,
  output logic                rowStart,
  output logic                arzPulse
);
  seq_strobe_t strb;

  rowseq_ctrl #(.MAX_ROWS(MAX_ROWS), .LEN_W(LEN_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .rowLen   (rowLen),
    .numRows  (numRows),
    .rowIdx   (rowIdx),
    .strb     (strb),
    .rowStart (rowStart),
    .arzPulse (arzPulse)
  );

  rowseq_datapath #(.MAX_ROWS(MAX_ROWS)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .rowIdx (rowIdx),
    .rowSel (rowSel)
  );
endmodule

// File: tb/row_mux_sequencer_tb.sv
`timescale 1ns/100ps
module row_mux_sequencer_tb;
  localparam int MAXR  = 8;
  localparam int LENW  = 5;
  localparam int ROWW  = $clog2(MAXR);
  localparam int CNTW  = $clog2(MAXR + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            enable = 1'b0;
  logic [LENW-1:0] rowLen = 5'd4;
  logic [CNTW-1:0] numRows = 4'd2;
  logic [ROWW-1:0] rowIdx;
  logic [MAXR-1:0] rowSel;
  logic            rowStart;
  logic            arzPulse;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // model state
  int eRun = 0, eC = 0, eR = 0, eL = 3, eN = 1;
  int expSel = 0, prevSel = 0;
  int sinceStart = 0, startLen = 0;
  bit haveStart = 0;

  always #2.5 clk = ~clk;

  row_mux_sequencer #(.MAX_ROWS(MAXR), .LEN_W(LENW)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rowLen(rowLen),
    .numRows(numRows), .rowIdx(rowIdx), .rowSel(rowSel),
    .rowStart(rowStart), .arzPulse(arzPulse)
  );

  function automatic int clampL(int v);
    return (v < 3) ? 3 : v;
  endfunction

  function automatic int clampN(int v);
    if (v == 0) return 1;
    if (v > MAXR) return MAXR;
    return v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    if (!enable) begin
      eRun = 0; eC = 0; eR = 0; haveStart = 0;
    end else if (eRun == 0) begin
      eRun = 1; eC = 0; eR = 0;
      eL = clampL(int'(rowLen)); eN = clampN(int'(numRows));
    end else if (eC == eL - 1) begin
      eC = 0;
      if (eR == eN - 1) begin
        eR = 0;
        eL = clampL(int'(rowLen)); eN = clampN(int'(numRows));
      end else eR++;
    end else eC++;
    expSel = (eRun == 1 && eC >= 2) ? (1 << eR) : 0;
  endtask

  // one clock: model at posedge, falling-edge check just after posedge, full check after negedge
  task automatic runCycles(string tag, int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      modelStep();
      sinceStart++;
      #1;
      chk({tag, "/R10 rowSel before falling edge"}, int'(rowSel), prevSel);
      @(negedge clk);
      #1;
      chk({tag, "/R2 rowIdx"}, int'(rowIdx), eR);
      chk({tag, "/R3 rowSel"}, int'(rowSel), expSel);
      chk({tag, "/R4 rowStart"}, int'(rowStart), (eRun == 1 && eC == 0) ? 1 : 0);
      chk({tag, "/R5 arzPulse"}, int'(arzPulse), (eRun == 1 && eC == 0 && eR == 0) ? 1 : 0);
      if (rowStart) begin
        if (haveStart) chk({tag, "/R1 row length"}, sinceStart, startLen);
        haveStart = 1;
        sinceStart = 0;
        startLen = eL;
      end
      prevSel = expSel;
    end
  endtask

  task automatic checkResetState(string tag);
    chk({tag, "/R9 rowSel"}, int'(rowSel), 0);
    chk({tag, "/R9 rowIdx"}, int'(rowIdx), 0);
    chk({tag, "/R9 rowStart"}, int'(rowStart), 0);
    chk({tag, "/R9 arzPulse"}, int'(arzPulse), 0);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    int lens[3];
    int rows[5];
    lens = '{3, 4, 6};
    rows = '{1, 2, 3, 5, 8};

    // R9: state during reset
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    checkResetState("R9 initial");
    rst_n = 1'b1;
    runCycles("R8 idle", 2);

    // R1 sweep over row length and row count, two frames each
    foreach (lens[a]) begin
      foreach (rows[b]) begin
        rowLen = LENW'(lens[a]);
        numRows = CNTW'(rows[b]);
        enable = 1'b1;
        runCycles("R1 sweep", 2 * lens[a] * rows[b] + 3);
        enable = 1'b0;
        runCycles("R8 stop", 2);
      end
    end

    // R7: clamps on short rows and out-of-range counts
    for (int l = 0; l < 3; l++) begin
      rowLen = LENW'(l);
      numRows = 4'd0;
      enable = 1'b1;
      runCycles("R7 low", 8);
      enable = 1'b0;
      runCycles("R7 stop", 1);
    end
    rowLen = 5'd3;
    numRows = 4'd12;
    enable = 1'b1;
    runCycles("R7 high", 2 * 3 * 8 + 2);
    numRows = 4'd15;
    runCycles("R7 high", 2 * 3 * 8 + 2);
    enable = 1'b0;
    runCycles("R7 stop", 2);

    // R6: settings change mid-frame only take effect at the wrap
    rowLen = 5'd4;
    numRows = 4'd3;
    enable = 1'b1;
    runCycles("R6 old", 5);
    rowLen = 5'd6;
    numRows = 4'd2;
    runCycles("R6 change", 4 * 3 + 2 * 6 * 2);
    enable = 1'b0;
    runCycles("R6 stop", 2);

    // R8: enable dropped while a select is on, then restarted
    rowLen = 5'd7;
    numRows = 4'd4;
    enable = 1'b1;
    runCycles("R8 run", 11);
    enable = 1'b0;
    runCycles("R8 drop", 3);
    enable = 1'b1;
    runCycles("R8 restart", 30);

    // R9: asynchronous reset in the middle of a row
    rst_n = 1'b0;
    #1;
    checkResetState("R9 async");
    eRun = 0; eC = 0; eR = 0; expSel = 0; prevSel = 0; haveStart = 0;
    @(negedge clk); #1;
    checkResetState("R9 held");
    rst_n = 1'b1;
    runCycles("R9 after", 2 * 7 * 4 + 2);
    enable = 1'b0;
    runCycles("R9 stop", 2);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule